// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Write Front End

This block is the write-side slave controller for a two-wire serial memory of 1024 bytes. It takes SCL and SDA samples that have already been synchronised to the system clock. From them it finds bus START and STOP conditions and assembles bytes on rising SCL edges. It then runs the write transaction: control byte, word address, then one or more data bytes. Its outputs are strobes for a memory model. One strobe loads the address pointer, another writes a data byte into the page buffer, and a third requests the internal write cycle when the bus is released. It also decides when to pull SDA low for the acknowledge clock.

The 10-bit location is built from two sources. Bits 9:8 come from two positions of the control byte, and bits 7:0 come from the word-address byte. Data bytes inside one transaction advance only the low page bits of the pointer, so a long burst wraps within its 16-byte page. The block stays silent while the external write-cycle timer reports busy, which lets a master poll for completion. When the write-protect input is high, it accepts the control and address bytes but refuses the first data byte.

Top module: `eepw_slave_wr`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one abandons any partly received byte, restarts bit counting and releases `sda_pull`. A complete control byte sent after a mid-byte START is still decoded correctly.
- R2: The control byte is received MSB first. Bits 7:4 must be 1010, bit 3 must equal `strap_sel`, bits 2:1 give address bits 9:8, and bit 0 is the direction (0 = write). A matching write control byte is acknowledged: `sda_pull` is high from the SCL fall after the eighth bit until the SCL fall that ends the ninth clock.
- R3: A control byte with the wrong device code, the wrong bit 3, or bit 0 = 1 is not acknowledged. No later byte is acknowledged and no strobe is issued until the next START.
- R4: While `busy` is high, no control byte is acknowledged, including a matching write control byte.
- R5: The byte after an accepted control byte is acknowledged. It also gives a one-cycle `ptr_load` pulse with `ptr_addr` = {control bits 2:1, byte}.
- R6: Each data byte accepted with `wp` low is acknowledged. It gives a one-cycle `byte_wr` pulse, with `wr_addr` equal to the pointer before the byte and `wr_data` equal to the byte. The pointer's low 4 bits then increment modulo 16 and bits 9:4 stay fixed.
- R7: With `wp` high, the control and address bytes are still acknowledged. The first data byte is not acknowledged, no `byte_wr` is issued, and the following STOP raises no `commit_req`.
- R8: `commit_req` is a one-cycle pulse issued only for a STOP that follows at least one accepted data byte in the same transaction. A STOP after only control and address bytes raises no pulse.
- R9: `sda_pull` changes only while SCL is low, except for the release forced by START or STOP.
- R10: After reset, `sda_pull`, `ptr_load`, `byte_wr` and `commit_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (resolved bus level) |
| strap_sel | input | 1 | Strap value compared with control bit 3 |
| wp | input | 1 | Write protect; refuses data bytes when high |
| busy | input | 1 | Internal write cycle in progress |
| sda_pull | output | 1 | High to pull SDA low (acknowledge) |
| ptr_load | output | 1 | One-cycle pulse: address pointer loaded |
| ptr_addr | output | 10 | Current address pointer |
| byte_wr | output | 1 | One-cycle pulse: data byte accepted |
| wr_addr | output | 10 | Target location of the accepted byte |
| wr_data | output | 8 | Accepted data byte |
| commit_req | output | 1 | One-cycle pulse: start the internal write cycle |

## Verification
Some rules are checked by the assertions on every cycle. The acknowledge drive must only move while SCL is low, and START or STOP must clear the bit counter. A byte strobe must never appear after write protect, and it must always advance the page pointer within the page. A commit must follow a STOP. The directed scenarios are the only place to see decoding of each control-byte field, silence while busy, and the page wrap on a long burst. They also cover the missing commit for an address-only transaction and recovery from a mid-byte restart, all of which depend on whole bus sequences.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    localparam int BYTE_W = 8;
    localparam int HI_W   = 2;
    localparam int ADDR_W = BYTE_W + HI_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef struct packed {
        logic [3:0]      code;
        logic            sel;
        logic [HI_W-1:0] hi;
        logic            rd;
    } ctrl_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CTRL,
        S_ADDR,
        S_DATA
    } wstate_e;

    function automatic logic ctrl_hit(ctrl_t c, logic strap);
        return (c.code == DEV_CODE) && (c.sel == strap) && !c.rd;
    endfunction

    function automatic logic [ADDR_W-1:0] page_step(logic [ADDR_W-1:0] a,
                                                     logic [ADDR_W-1:0] mask);
        logic [ADDR_W-1:0] inc;
        inc = a + 1'b1;
        return (a & ~mask) | (inc & mask);
    endfunction

endpackage

// File: rtl/eepw_bus_events.sv
module eepw_bus_events
    import eepw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    always_comb begin
        ev.scl_rise = !scl_d && scl;
        ev.scl_fall = scl_d && !scl;
        ev.start    = scl_d && scl && sda_d && !sda;
        ev.stop     = scl_d && scl && !sda_d && sda;
    end

endmodule

// File: rtl/eepw_byte_engine.sv
module eepw_byte_engine
    import eepw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl,
    input  logic              sda,
    input  bus_ev_t           ev,
    input  logic              ack_want,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_done,
    output logic              sda_pull
);

    logic [CNT_W-1:0] bit_cnt;
    logic             ack_phase;
    logic             ack_pend;

    always_ff @(posedge clk) begin
        if (rst || ev.start || ev.stop) begin
            bit_cnt   <= '0;
            ack_phase <= 1'b0;
            ack_pend  <= 1'b0;
            sda_pull  <= 1'b0;
            byte_done <= 1'b0;
            if (rst) rx_byte <= '0;
        end else begin
            byte_done <= 1'b0;
            if (byte_done) ack_pend <= ack_want;
            if (ev.scl_rise && !ack_phase && bit_cnt < CNT_W'(BYTE_W)) begin
                rx_byte <= {rx_byte[BYTE_W-2:0], sda};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) byte_done <= 1'b1;
            end
            if (ev.scl_fall) begin
                if (!ack_phase && bit_cnt == CNT_W'(BYTE_W)) begin
                    ack_phase <= 1'b1;
                    sda_pull  <= ack_pend;
                end else if (ack_phase) begin
                    ack_phase <= 1'b0;
                    sda_pull  <= 1'b0;
                    bit_cnt   <= '0;
                end
            end
        end
    end

    // R9
    ack_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> (!scl || $past(ev.start || ev.stop)));

    // R1
    cond_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |=> (bit_cnt == '0 && !sda_pull));

endmodule

// File: rtl/eepw_txn_ctrl.sv
module eepw_txn_ctrl
    import eepw_pkg::*;
#(
    parameter int PAGE_W = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              strap,
    input  logic              wp,
    input  logic              busy,
    output logic              ack_want,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic              byte_wr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              commit_req
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);

    wstate_e         state;
    logic            wrote;
    logic [HI_W-1:0] hi_q;
    ctrl_t           ctrl;

    assign ctrl = ctrl_t'(rx_byte);

    always_comb begin
        unique case (state)
            S_CTRL:  ack_want = ctrl_hit(ctrl, strap) && !busy;
            S_ADDR:  ack_want = 1'b1;
            S_DATA:  ack_want = !wp;
            default: ack_want = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            wrote      <= 1'b0;
            hi_q       <= '0;
            ptr_addr   <= '0;
            ptr_load   <= 1'b0;
            byte_wr    <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            commit_req <= 1'b0;
        end else begin
            ptr_load   <= 1'b0;
            byte_wr    <= 1'b0;
            commit_req <= 1'b0;
            if (ev.start) begin
                state <= S_CTRL;
                wrote <= 1'b0;
            end else if (ev.stop) begin
                commit_req <= (state == S_DATA) && wrote;
                state      <= S_IDLE;
                wrote      <= 1'b0;
            end else if (byte_done) begin
                unique case (state)
                    S_CTRL: begin
                        if (ack_want) begin
                            hi_q  <= ctrl.hi;
                            state <= S_ADDR;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                    S_ADDR: begin
                        ptr_addr <= {hi_q, rx_byte};
                        ptr_load <= 1'b1;
                        state    <= S_DATA;
                    end
                    S_DATA: begin
                        if (ack_want) begin
                            byte_wr  <= 1'b1;
                            wr_addr  <= ptr_addr;
                            wr_data  <= rx_byte;
                            ptr_addr <= page_step(ptr_addr, PAGE_MASK);
                            wrote    <= 1'b1;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R7
    no_wr_under_wp_chk: assert property (@(posedge clk) disable iff (rst)
        byte_wr |-> !$past(wp));

    // R6
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        byte_wr |-> ((ptr_addr & ~PAGE_MASK) == (wr_addr & ~PAGE_MASK)
                     && (ptr_addr & PAGE_MASK) == ((wr_addr + 1'b1) & PAGE_MASK)));

    // R8
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        commit_req |-> $past(ev.stop));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ptr_load, byte_wr, commit_req}));

endmodule

// File: rtl/eepw_slave_wr.sv
module eepw_slave_wr
    import eepw_pkg::*;
#(
    parameter int PAGE_W = 4
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        strap_sel,
    input  logic        wp,
    input  logic        busy,
    output logic        sda_pull,
    output logic        ptr_load,
    output logic [9:0]  ptr_addr,
    output logic        byte_wr,
    output logic [9:0]  wr_addr,
    output logic [7:0]  wr_data,
    output logic        commit_req
);

    bus_ev_t           ev;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_done;
    logic              ack_want;

    eepw_bus_events u_ev (
        .clk (clk),
        .rst (rst),
        .scl (scl_i),
        .sda (sda_i),
        .ev  (ev)
    );

    eepw_byte_engine u_bytes (
        .clk       (clk),
        .rst       (rst),
        .scl       (scl_i),
        .sda       (sda_i),
        .ev        (ev),
        .ack_want  (ack_want),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .sda_pull  (sda_pull)
    );

    eepw_txn_ctrl #(.PAGE_W(PAGE_W)) u_txn (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .strap      (strap_sel),
        .wp         (wp),
        .busy       (busy),
        .ack_want   (ack_want),
        .ptr_load   (ptr_load),
        .ptr_addr   (ptr_addr),
        .byte_wr    (byte_wr),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit_req (commit_req)
    );

endmodule

// File: tb/eepw_slave_wr_test.sv
module eepw_slave_wr_test;

    localparam int CLK_PERIOD = 10;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap_sel = 1'b1;
    logic       wp = 1'b0;
    logic       busy = 1'b0;
    logic       sda_pull, ptr_load, byte_wr, commit_req;
    logic [9:0] ptr_addr, wr_addr;
    logic [7:0] wr_data;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int n_wr = 0, n_ld = 0, n_cm = 0;
    logic [9:0] last_ld;
    logic [9:0] log_a [16];
    logic [7:0] log_d [16];

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    eepw_slave_wr uut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .strap_sel(strap_sel), .wp(wp), .busy(busy),
        .sda_pull(sda_pull), .ptr_load(ptr_load), .ptr_addr(ptr_addr),
        .byte_wr(byte_wr), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_req(commit_req)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (ptr_load) begin last_ld = ptr_addr; n_ld++; end
            if (byte_wr) begin
                log_a[n_wr % 16] = wr_addr;
                log_d[n_wr % 16] = wr_data;
                n_wr++;
            end
            if (commit_req) n_cm++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_n(H);
        scl = 1'b1;   wait_n(H);
        sda_m = 1'b0; wait_n(H);
        scl = 1'b0;   wait_n(H);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_n(H);
        scl = 1'b1;   wait_n(H);
        sda_m = 1'b1; wait_n(H);
    endtask

    task automatic send_bit(input logic b);
        wait_n(H); sda_m = b;
        wait_n(H); scl = 1'b1;
        wait_n(H); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wait_n(H); sda_m = 1'b1;
        wait_n(H); scl = 1'b1;
        wait_n(2);
        acked = (sda_line == 1'b0);
        wait_n(H - 2); scl = 1'b0;
        wait_n(H);
        chk(sda_pull == 1'b0, "R9 release after ninth clock", sda_pull, 0);
    endtask

    task automatic t_reset;
        chk(sda_pull == 0 && ptr_load == 0 && byte_wr == 0 && commit_req == 0,
            "R10 reset outputs", {sda_pull, ptr_load, byte_wr, commit_req}, 0);
    endtask

    task automatic t_byte_write;
        logic a;
        int w0, l0, c0;
        w0 = n_wr; l0 = n_ld; c0 = n_cm;
        bus_start;
        send_byte(8'hAC, a); chk(a, "R2 control ack", a, 1);
        send_byte(8'h35, a); chk(a, "R5 address ack", a, 1);
        chk(n_ld == l0 + 1 && last_ld == 10'h235, "R5 pointer load", last_ld, 10'h235);
        send_byte(8'h5A, a); chk(a, "R6 data ack", a, 1);
        chk(n_wr == w0 + 1, "R6 one byte strobe", n_wr - w0, 1);
        chk(log_a[w0 % 16] == 10'h235 && log_d[w0 % 16] == 8'h5A,
            "R6 byte target", {log_a[w0 % 16], log_d[w0 % 16]}, {10'h235, 8'h5A});
        bus_stop; wait_n(H);
        chk(n_cm == c0 + 1, "R8 commit on stop", n_cm - c0, 1);
    endtask

    task automatic t_page_wrap;
        logic a;
        int w0;
        logic [9:0] exp_a [3];
        exp_a[0] = 10'h11E; exp_a[1] = 10'h11F; exp_a[2] = 10'h110;
        w0 = n_wr;
        bus_start;
        send_byte(8'hAA, a);
        send_byte(8'h1E, a);
        for (int i = 0; i < 3; i++) send_byte(8'hC0 + 8'(i), a);
        bus_stop; wait_n(H);
        chk(n_wr == w0 + 3, "R6 burst count", n_wr - w0, 3);
        for (int i = 0; i < 3; i++)
            chk(log_a[(w0 + i) % 16] == exp_a[i], "R6 page wrap address",
                log_a[(w0 + i) % 16], exp_a[i]);
    endtask

    task automatic t_mismatch;
        logic a;
        int l0, c0;
        logic [7:0] bad [3];
        bad[0] = 8'hBC; bad[1] = 8'hA4; bad[2] = 8'hAD;
        l0 = n_ld; c0 = n_cm;
        for (int i = 0; i < 3; i++) begin
            bus_start;
            send_byte(bad[i], a); chk(!a, "R3 refused control byte", a, 0);
            send_byte(8'h12, a);  chk(!a, "R3 ignored until start", a, 0);
            bus_stop; wait_n(H);
        end
        chk(n_ld == l0 && n_cm == c0, "R3 no strobes", n_ld - l0, 0);
    endtask

    task automatic t_busy_poll;
        logic a;
        busy = 1'b1;
        bus_start;
        send_byte(8'hAC, a); chk(!a, "R4 no ack while busy", a, 0);
        bus_stop;
        busy = 1'b0;
        bus_start;
        send_byte(8'hAC, a); chk(a, "R4 ack once idle", a, 1);
        bus_stop; wait_n(H);
    endtask

    task automatic t_protect;
        logic a;
        int w0, c0;
        w0 = n_wr; c0 = n_cm;
        wp = 1'b1;
        bus_start;
        send_byte(8'hAC, a); chk(a, "R7 control ack under wp", a, 1);
        send_byte(8'h40, a); chk(a, "R7 address ack under wp", a, 1);
        send_byte(8'h77, a); chk(!a, "R7 data refused", a, 0);
        bus_stop; wait_n(H);
        wp = 1'b0;
        chk(n_wr == w0, "R7 no byte strobe", n_wr - w0, 0);
        chk(n_cm == c0, "R7 no commit", n_cm - c0, 0);
    endtask

    task automatic t_addr_only;
        logic a;
        int c0;
        c0 = n_cm;
        bus_start;
        send_byte(8'hAC, a);
        send_byte(8'h09, a);
        bus_stop; wait_n(H);
        chk(n_cm == c0, "R8 no commit without data", n_cm - c0, 0);
    endtask

    task automatic t_abort;
        logic a;
        bus_start;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start;
        send_byte(8'hAC, a); chk(a, "R1 decode after restart", a, 1);
        send_bit(1'b0); send_bit(1'b1);
        bus_stop; wait_n(H);
        chk(sda_pull == 0, "R1 stop releases", sda_pull, 0);
        bus_start;
        send_byte(8'hAE, a); chk(a, "R1 decode after aborted stop", a, 1);
        bus_stop; wait_n(H);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        t_reset;
        t_byte_write;
        t_page_wrap;
        t_mismatch;
        t_busy_poll;
        t_protect;
        t_addr_only;
        t_abort;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule